// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block sits beside the retire stage of a small CPU core and decides, every clock, whether a hardware breakpoint or data watch has fired. It keeps four breakpoint address slots, a control word that gives each slot an enable, a kind (execute, write watch, I/O, read-or-write watch) and a span length, and a status word whose low bits record which slots matched. Execute-kind slots are compared against the retiring instruction address inside the block. Watch-kind slots rely on the load/store path: the block hands it each slot's aligned base address, byte mask and arming, and takes back one hit strobe per slot.

When any slot matches, the match vector replaces the low status bits. It is written only if one of the matching slots is enabled, or if the core asks for a forced update. An enabled match also raises a one-cycle debug exception request towards the core's trap logic. Software reaches all six registers through a simple select/write-enable port with a combinational read. Every input is a single-cycle strobe or level sampled at the clock edge. No stream passes through the block, so it has no valid/ready handshake and no back-pressure: every input is taken in the cycle it is presented.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset the four address slots read 0, the status register reads 0xFFFF0FF0, the control register reads 0x00000400 and dbg_req is low.
- R2: reg_sel 0..3 selects address slots 0..3, 4 the status register and 5 the control register. A write with reg_wr_en takes effect at the clock edge, and reg_rdata shows the selected register combinationally. A status or control write stores the written data ORed with that register's reset pattern. reg_sel 6 and 7 read 0, and writes to them change nothing.
- R3: For slot n, the enable is control bit 2n OR bit 2n+1, the 2-bit kind is control bits [17+4n:16+4n] and the 2-bit length is control bits [19+4n:18+4n]. Kind 0 is execute, 1 is write watch, 2 is I/O and 3 is read-or-write watch.
- R4: An execute-kind slot matches in a cycle when retire_valid is high and its address equals retire_pc.
- R5: A slot whose kind has bit 0 set (write or read-or-write watch) matches when watch_hit[n] is high. An I/O-kind slot never matches.
- R6: At each edge the candidate status is the current status with bits [3:0] replaced by the match vector, including matches of disabled slots. It is stored only when an enabled slot matched or force_update is high. Otherwise the status register keeps its value.
- R7: dbg_req is high in the cycle after a cycle in which at least one enabled slot matched, and low otherwise.
- R8: In a cycle in which software writes the control register, the evaluation is discarded: the status register is not updated by matches or force_update, and dbg_req stays low in the next cycle.
- R9: A software write to the status register in the same cycle as an evaluation commit wins over the commit. dbg_req still follows R7.
- R10: watch_arm[n] is high when slot n is enabled and its kind has bit 0 set. watch_rw[n] is high when its kind is 3. watch_mask[n] is 0 for length 00, 1 for 01, 3 for 11 and 7 for 10. watch_base[n] is the slot address with the masked low bits cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | 32 | Address of the retiring instruction |
| watch_hit | input | 4 | Per-slot data access hit from the load/store path |
| force_update | input | 1 | Commit the status candidate even without an enabled match |
| dbg_req | output | 1 | Debug exception request |
| watch_arm | output | 4 | Per-slot watch active |
| watch_rw | output | 4 | Per-slot watch covers reads as well as writes |
| watch_base | output | 128 | Per-slot aligned watch base address, slot n at [32n+31:32n] |
| watch_mask | output | 12 | Per-slot low-address byte mask, slot n at [3n+2:3n] |

## Verification
The hardest case to reach is a cycle where matches from enabled and disabled slots mix, and where that cycle also carries a control write, a status write or force_update. Only then do the recording, commit and suppression rules pull against each other. The stimulus first programs a control word with one slot of every kind and a mix of enables. It then drives directed cycles that line up retire addresses and watch strobes with those slots, some together with register writes. A long randomized phase follows, with retire addresses drawn mostly from the programmed slot addresses, so that these collisions keep recurring.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  typedef enum logic [1:0] {
    BRK_EXEC  = 2'b00,
    BRK_WRITE = 2'b01,
    BRK_IO    = 2'b10,
    BRK_RW    = 2'b11
  } brk_kind_e;

  localparam int MASK_W = 3;

  // byte-span mask for the length code of a watch slot
  function automatic logic [MASK_W-1:0] span_mask(input logic [1:0] len);
    case (len)
      2'b00:   span_mask = 3'b000;
      2'b01:   span_mask = 3'b001;
      2'b11:   span_mask = 3'b011;
      default: span_mask = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/dbgm_ctrl.sv
module dbgm_ctrl
  import dbgm_pkg::*;
#(
  parameter int          NUM_SLOTS   = 4,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] CTRL_FIXED1 = 32'h0000_0400
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         ctrl_q,
  output logic [NUM_SLOTS-1:0]      slot_en,
  output logic [NUM_SLOTS-1:0][1:0] slot_kind,
  output logic [NUM_SLOTS-1:0][1:0] slot_len
);

  localparam int KIND_BASE = 16;
  localparam int LEN_BASE  = 18;
  localparam int FIELD_STR = 4;
  localparam logic [DATA_W-1:0] FIXED = DATA_W'(CTRL_FIXED1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= FIXED;
    else if (wr_en) ctrl_q <= wdata | FIXED;
  end

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_field
    assign slot_en[n]   = ctrl_q[2*n] | ctrl_q[2*n+1];
    assign slot_kind[n] = ctrl_q[KIND_BASE + FIELD_STR*n +: 2];
    assign slot_len[n]  = ctrl_q[LEN_BASE + FIELD_STR*n +: 2];
  end

  AST_CTRL_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & FIXED) == FIXED);  // R2

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));  // R2

endmodule

// File: rtl/dbgm_slot.sv
module dbgm_slot
  import dbgm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              enable,
  input  logic [1:0]        kind_raw,
  input  logic [1:0]        len,
  input  logic              retire_valid,
  input  logic [DATA_W-1:0] retire_pc,
  input  logic              ls_hit,
  output logic [DATA_W-1:0] addr_q,
  output logic              hit,
  output logic              arm,
  output logic              rw,
  output logic [DATA_W-1:0] base,
  output logic [MASK_W-1:0] mask
);

  brk_kind_e kind;
  logic      exec_hit;
  logic      watch_kind;

  assign kind = brk_kind_e'(kind_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= wdata;
  end

  assign watch_kind = kind_raw[0];
  assign exec_hit   = (kind == BRK_EXEC) && retire_valid && (addr_q == retire_pc);
  assign hit        = exec_hit || (watch_kind && ls_hit);

  assign arm  = enable && watch_kind;
  assign rw   = (kind == BRK_RW);
  assign mask = span_mask(len);
  assign base = addr_q & ~{{(DATA_W-MASK_W){1'b0}}, mask};

  AST_IO_SLOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BRK_IO) |-> !hit);  // R5

  AST_EXEC_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BRK_EXEC && !retire_valid) |-> !hit);  // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));  // R2

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (base[MASK_W-1:0] & mask) == '0);  // R10

endmodule

// File: rtl/dbgm_status.sv
module dbgm_status #(
  parameter int          NUM_SLOTS   = 4,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] STAT_FIXED1 = 32'hFFFF_0FF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] hits,
  input  logic [NUM_SLOTS-1:0] slot_en,
  input  logic                 force_update,
  input  logic                 ctrl_wr,
  input  logic                 stat_wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    stat_q,
  output logic                 dbg_req
);

  localparam logic [DATA_W-1:0] FIXED = DATA_W'(STAT_FIXED1);

  logic [DATA_W-1:0] candidate;
  logic [DATA_W-1:0] stat_d;
  logic              en_hit;
  logic              commit;

  always_comb begin
    candidate                = stat_q;
    candidate[NUM_SLOTS-1:0] = hits;
  end

  assign en_hit = |(hits & slot_en);
  assign commit = !ctrl_wr && (en_hit || force_update);

  always_comb begin
    if (stat_wr)     stat_d = wdata | FIXED;
    else if (commit) stat_d = candidate;
    else             stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= FIXED;
      dbg_req <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      dbg_req <= en_hit && !ctrl_wr;
    end
  end

  AST_REQ_AFTER_ENABLED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hits & slot_en) && !ctrl_wr) |=> dbg_req);  // R7

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> $past(|(hits & slot_en)));  // R7

  AST_CTRL_WR_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !dbg_req);  // R8

  AST_STAT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && !force_update && !(|(hits & slot_en))) |=> $stable(stat_q));  // R6

  AST_STAT_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & FIXED) == FIXED);  // R2

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbgm_pkg::*;
#(
  parameter int          NUM_SLOTS   = 4,
  parameter int          DATA_W      = 32,
  parameter int          SEL_W       = 3,
  parameter logic [31:0] STAT_FIXED1 = 32'hFFFF_0FF0,
  parameter logic [31:0] CTRL_FIXED1 = 32'h0000_0400
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_en,
  input  logic [SEL_W-1:0]              reg_sel,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic                          retire_valid,
  input  logic [DATA_W-1:0]             retire_pc,
  input  logic [NUM_SLOTS-1:0]          watch_hit,
  input  logic                          force_update,
  output logic                          dbg_req,
  output logic [NUM_SLOTS-1:0]          watch_arm,
  output logic [NUM_SLOTS-1:0]          watch_rw,
  output logic [NUM_SLOTS*DATA_W-1:0]   watch_base,
  output logic [NUM_SLOTS*MASK_W-1:0]   watch_mask
);

  localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_SLOTS);
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_SLOTS + 1);

  logic [DATA_W-1:0]         ctrl_q;
  logic [DATA_W-1:0]         stat_q;
  logic [NUM_SLOTS-1:0]      slot_en;
  logic [NUM_SLOTS-1:0][1:0] slot_kind;
  logic [NUM_SLOTS-1:0][1:0] slot_len;
  logic [NUM_SLOTS-1:0]      hits;
  logic [DATA_W-1:0]         addr_q [NUM_SLOTS];
  logic                      ctrl_wr;
  logic                      stat_wr;

  assign ctrl_wr = reg_wr_en && (reg_sel == SEL_CTRL);
  assign stat_wr = reg_wr_en && (reg_sel == SEL_STAT);

  dbgm_ctrl #(
    .NUM_SLOTS  (NUM_SLOTS),
    .DATA_W     (DATA_W),
    .CTRL_FIXED1(CTRL_FIXED1)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wdata    (reg_wdata),
    .ctrl_q   (ctrl_q),
    .slot_en  (slot_en),
    .slot_kind(slot_kind),
    .slot_len (slot_len)
  );

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    dbgm_slot #(.DATA_W(DATA_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr_en && (reg_sel == SEL_W'(n))),
      .wdata       (reg_wdata),
      .enable      (slot_en[n]),
      .kind_raw    (slot_kind[n]),
      .len         (slot_len[n]),
      .retire_valid(retire_valid),
      .retire_pc   (retire_pc),
      .ls_hit      (watch_hit[n]),
      .addr_q      (addr_q[n]),
      .hit         (hits[n]),
      .arm         (watch_arm[n]),
      .rw          (watch_rw[n]),
      .base        (watch_base[n*DATA_W +: DATA_W]),
      .mask        (watch_mask[n*MASK_W +: MASK_W])
    );
  end

  dbgm_status #(
    .NUM_SLOTS  (NUM_SLOTS),
    .DATA_W     (DATA_W),
    .STAT_FIXED1(STAT_FIXED1)
  ) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .hits        (hits),
    .slot_en     (slot_en),
    .force_update(force_update),
    .ctrl_wr     (ctrl_wr),
    .stat_wr     (stat_wr),
    .wdata       (reg_wdata),
    .stat_q      (stat_q),
    .dbg_req     (dbg_req)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (reg_sel == SEL_W'(i)) reg_rdata = addr_q[i];
    end
    if (reg_sel == SEL_STAT) reg_rdata = stat_q;
    if (reg_sel == SEL_CTRL) reg_rdata = ctrl_q;
  end

  AST_REQ_IS_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hits == '0) |=> !dbg_req);  // R7

  AST_ARM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_arm & ~slot_en) == '0);  // R10

endmodule

// File: tb/tb_dbg_match_unit.sv
module tb_dbg_match_unit;

  localparam int N = 4;
  localparam logic [31:0] SFIX = 32'hFFFF_0FF0;
  localparam logic [31:0] CFIX = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        retire_valid = 1'b0;
  logic [31:0] retire_pc = '0;
  logic [3:0]  watch_hit = '0;
  logic        force_update = 1'b0;
  logic        dbg_req;
  logic [3:0]  watch_arm;
  logic [3:0]  watch_rw;
  logic [127:0] watch_base;
  logic [11:0] watch_mask;

  always #4 clk = ~clk;

  dbg_match_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .retire_valid(retire_valid),
    .retire_pc(retire_pc), .watch_hit(watch_hit), .force_update(force_update),
    .dbg_req(dbg_req), .watch_arm(watch_arm), .watch_rw(watch_rw),
    .watch_base(watch_base), .watch_mask(watch_mask)
  );

  // reference state
  logic [31:0] m_addr [N];
  logic [31:0] m_stat, m_ctrl;
  logic        m_req;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] s);
    if (s < 3'd4) return m_addr[s[1:0]];
    if (s == 3'd4) return m_stat;
    if (s == 3'd5) return m_ctrl;
    return 32'h0;
  endfunction

  function automatic logic [2:0] m_mask(input logic [1:0] l);
    case (l)
      2'b00: return 3'd0;
      2'b01: return 3'd1;
      2'b11: return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  task automatic compare_all(input string tag);
    chk(tag, "rdata", 128'(reg_rdata), 128'(m_read(reg_sel)));
    chk("R7", "dbg_req", 128'(dbg_req), 128'(m_req));
    for (int n = 0; n < N; n++) begin
      logic [1:0] ty, ln;
      logic en;
      ty = m_ctrl[16+4*n +: 2];
      ln = m_ctrl[18+4*n +: 2];
      en = m_ctrl[2*n] | m_ctrl[2*n+1];
      chk("R10", "watch_arm", 128'(watch_arm[n]), 128'(en & ty[0]));
      chk("R10", "watch_rw", 128'(watch_rw[n]), 128'(ty == 2'b11));
      chk("R10", "watch_mask", 128'(watch_mask[3*n +: 3]), 128'(m_mask(ln)));
      chk("R10", "watch_base", 128'(watch_base[32*n +: 32]),
          128'(m_addr[n] & ~{29'b0, m_mask(ln)}));
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [2:0] sel,
                      input logic [31:0] wd, input logic rv, input logic [31:0] pc,
                      input logic [3:0] wh, input logic fu);
    logic [3:0] hv;
    logic       hen, cw;
    logic [31:0] ns;
    @(negedge clk);
    reg_wr_en = we; reg_sel = sel; reg_wdata = wd;
    retire_valid = rv; retire_pc = pc; watch_hit = wh; force_update = fu;
    #1;
    compare_all(tag);
    hv = '0; hen = 1'b0;
    for (int n = 0; n < N; n++) begin
      logic [1:0] ty;
      ty = m_ctrl[16+4*n +: 2];
      if (ty == 2'b00 && rv && m_addr[n] == pc) hv[n] = 1'b1;
      if (ty[0] && wh[n]) hv[n] = 1'b1;
      if (hv[n] && (m_ctrl[2*n] | m_ctrl[2*n+1])) hen = 1'b1;
    end
    cw = we && sel == 3'd5;
    ns = m_stat;
    if (we && sel == 3'd4) ns = wd | SFIX;
    else if (!cw && (hen || fu)) ns = {m_stat[31:4], hv};
    @(posedge clk);
    m_stat = ns;
    m_req  = hen && !cw;
    if (we && sel < 3'd4) m_addr[sel[1:0]] = wd;
    if (cw) m_ctrl = wd | CFIX;
  endtask

  task automatic rd(input string tag, input logic [2:0] sel);
    step(tag, 1'b0, sel, 32'h0, 1'b0, 32'h0, 4'h0, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [2:0] sel, input logic [31:0] d);
    step(tag, 1'b1, sel, d, 1'b0, 32'h0, 4'h0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < N; n++) m_addr[n] = '0;
    m_stat = SFIX; m_ctrl = CFIX; m_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values of every register
    for (int s = 0; s < 6; s++) rd("R1", 3'(s));

    // R2: register access, fixed ones, unused selects
    wr("R2", 3'd0, 32'h0000_1000);
    wr("R2", 3'd1, 32'h0000_2002);
    wr("R2", 3'd2, 32'h0000_3007);
    wr("R2", 3'd3, 32'h0000_400C);
    wr("R2", 3'd6, 32'hDEAD_BEEF);
    wr("R2", 3'd4, 32'h0000_0000);
    for (int s = 0; s < 8; s++) rd("R2", 3'(s));

    // R3: slot0 exec (global en), slot1 write len01 (local en),
    //     slot2 rw len11 disabled, slot3 io len10 enabled
    wr("R3", 3'd5, 32'h9E70_0000 | 32'h0000_0042 | 32'h0000_0010 & 32'h0);
    wr("R3", 3'd5, {4'b1010, 4'b1111, 4'b0101, 4'b0000, 8'h00, 8'b0100_0110});
    rd("R3", 3'd5);

    // R4: execution match
    step("R4", 1'b0, 3'd4, 32'h0, 1'b1, 32'h0000_1000, 4'h0, 1'b0);
    rd("R4", 3'd4);
    step("R4", 1'b0, 3'd4, 32'h0, 1'b1, 32'h0000_1004, 4'h0, 1'b0);
    step("R4", 1'b0, 3'd4, 32'h0, 1'b0, 32'h0000_1000, 4'h0, 1'b0);
    rd("R4", 3'd4);

    // R5: watch strobes on all slots
    step("R5", 1'b0, 3'd4, 32'h0, 1'b0, 32'h0, 4'hF, 1'b0);
    rd("R5", 3'd4);
    step("R5", 1'b0, 3'd4, 32'h0, 1'b0, 32'h0, 4'h8, 1'b0);
    rd("R5", 3'd4);

    // R6: disabled-only match held, then forced, then force alone
    step("R6", 1'b0, 3'd4, 32'h0, 1'b0, 32'h0, 4'h4, 1'b0);
    rd("R6", 3'd4);
    step("R6", 1'b0, 3'd4, 32'h0, 1'b0, 32'h0, 4'h4, 1'b1);
    rd("R6", 3'd4);
    step("R6", 1'b0, 3'd4, 32'h0, 1'b0, 32'h0, 4'h0, 1'b1);
    rd("R6", 3'd4);

    // R8: control write with an enabled hit and force
    step("R8", 1'b1, 3'd5, {4'b1010, 4'b1111, 4'b0101, 4'b0000, 8'h00, 8'b0100_0110},
         1'b1, 32'h0000_1000, 4'h2, 1'b1);
    rd("R8", 3'd4);

    // R9: status write together with an enabled hit
    step("R9", 1'b1, 3'd4, 32'h0000_0005, 1'b1, 32'h0000_1000, 4'h0, 1'b0);
    rd("R9", 3'd4);

    // mixed random traffic, retire addresses biased to slot addresses
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, pc;
      logic we;
      logic [2:0] sel;
      r = $urandom;
      we = (r[3:0] == 4'd0);
      sel = 3'(r[6:4]);
      pc = r[8] ? m_addr[r[10:9]] : 32'($urandom);
      step("R6", we, sel, (sel < 3'd4) ? 32'($urandom) & 32'h0000_FFFF : 32'($urandom),
           r[11], pc, 4'(r[15:12] & {4{r[16]}}), (r[20:17] == 4'd0));
    end

    rd("R6", 3'd4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule